// File: doc/BRIEF.md
# Ethernet Transmit Backoff Scheduler

This block decides the moment a frame transmission may begin on a shared Ethernet segment. A host command brings a word count. The scheduler then makes one attempt after another. For each attempt it grows a per-command load value, draws a value from a 16-bit pseudo-random generator built only from shifts and adds, and masks the two together to form a randomized wait in countdown-clock ticks. When the random wait comes out as zero, the scheduler instead enforces a minimum gap since the previous successful transmission ended. That gap is measured against a free-running time counter.

When the wait expires, the block emits a one-cycle transmit-enable pulse and then waits for the end-of-attempt report. A collision starts a new attempt silently. A normal end or any other abort posts a completion code with the masked hardware status. A zero word count and a load overflow each post their own error code, and no transmission is made in either case. The data words themselves are handled elsewhere.

Top module: `tx_backoff_sched`

## Requirements
- R1: After reset, tx_en and post_valid are low, and the load value and the generator state are both zero. As a result, the first attempt after reset uses a generator output of 13849 and a load of 0.
- R2: Each attempt advances the generator once, following R' = (R·2053 + 13849) mod 65536. The attempt uses the new value, and only its upper 8 bits (R' >> 8) take part in the wait. A command that posts the count-zero code does not advance the generator.
- R3: Each attempt replaces the load L with (2·L + 1) mod 65536 and computes with the old L. A command accepted while idle clears L to zero before its first attempt.
- R4: When w = (old L AND (R' >> 8)) · 2 is nonzero, no tx_en is issued until w tick pulses have arrived. The tx_en pulse appears in the cycle after the w-th tick.
- R5: When w is zero and the elapsed time (time_now − last end stamp) mod 65536 is at least 840, tx_en is asserted two clock cycles after the accepting cmd_start edge.
- R6: When w is zero and the elapsed time is below 840, the wait becomes ((840 − elapsed) >> 5) + 1 ticks, which is never zero.
- R7: An attempt whose old load has bit 15 set posts code 3 (load overflow) with status 0 and does not assert tx_en.
- R8: A command with cmd_count equal to 0 posts code 2 (count zero) with status 0, makes no attempt and does not assert tx_en.
- R9: An end report with end_abort=1 and end_collision=1 posts nothing and starts a new attempt under R2 to R7.
- R10: An end report with end_abort=1 and end_collision=0 posts code 1 with post_status = end_status AND 8'h3C, and leaves the last end stamp unchanged.
- R11: An end report with end_abort=0 posts code 0 with post_status = end_status AND 8'h3C, and records time_now as the last end stamp.
- R12: tx_en and post_valid are each one-cycle pulses, and they are never high in the same cycle.
- R13: cmd_start is ignored unless the scheduler is idle. A pending wait neither restarts nor posts because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Host transmit command strobe |
| cmd_count | input | 16 | Requested word count |
| time_now | input | 16 | Free-running time counter |
| tick | input | 1 | Countdown clock strobe |
| end_valid | input | 1 | End-of-attempt report strobe |
| end_abort | input | 1 | Attempt was aborted |
| end_collision | input | 1 | Abort cause was a collision |
| end_status | input | 8 | Raw hardware status of the attempt |
| tx_en | output | 1 | Pulse: transmission may start |
| post_valid | output | 1 | Pulse: completion code posted |
| post_code | output | 2 | 0 done, 1 abort, 2 count zero, 3 load overflow |
| post_status | output | 8 | Masked hardware status |

## Verification
The scheduler's timing is driven with fresh commands at elapsed gaps well above the minimum, exactly at it, one unit below it and far below it. These cases separate the immediate start from a spacing wait, and they show whether the shortfall is shifted and rounded up correctly. A chain of sixteen collisions exercises the randomized window over every load width. Each wait is counted tick by tick against a bench model of the generator, so a wrong multiplier, a wrong byte choice or a missing doubling shows up as a pulse that comes early or late. At the end of the chain the load overflows. Aborts with and without collision, a zero count, and a command issued in the middle of a wait separate the silent retry, the status posts and the idle-only acceptance of commands.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    POST_DONE     = 2'd0,
    POST_ABORT    = 2'd1,
    POST_CNT_ZERO = 2'd2,
    POST_LOAD_OVF = 2'd3
  } post_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ATTEMPT,
    ST_WAIT,
    ST_BUSY
  } sched_state_e;
endpackage

// File: rtl/txb_lcg.sv
module txb_lcg #(
  parameter int W    = 16,
  parameter int SH_A = 11,
  parameter int SH_B = 2,
  parameter int INC  = 13849
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value,
  output logic [W-1:0] next_value
);
  // multiply by (2^SH_A + 2^SH_B + 1) with shifts and adds only
  always_comb begin
    next_value = value + (value << SH_A) + (value << SH_B) + W'(INC);
  end

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= next_value;
  end

  // R2
  rng_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(value));
endmodule

// File: rtl/txb_load.sv
module txb_load #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] load_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) load_q <= '0;
    else if (step)    load_q <= {load_q[W-2:0], 1'b1};
  end

  // R3
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(load_q));
  // R3
  load_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> load_q[0]);
endmodule

// File: rtl/txb_wait_ctr.sv
module txb_wait_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  always_comb expire = tick && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load_en)            cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - CW'(1);
  end

  // R4
  cnt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && cnt == '0) |=> cnt == '0);
  // R4
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !tick) |=> $stable(cnt));
endmodule

// File: rtl/tx_backoff_sched.sv
module tx_backoff_sched #(
  parameter int W         = 16,
  parameter int CNT_W     = 16,
  parameter int STAT_W    = 8,
  parameter int STAT_MASK = 'h3C,
  parameter int RND_BITS  = 8,
  parameter int MIN_GAP   = 840,
  parameter int GAP_SHIFT = 5,
  parameter int LCG_INC   = 13849
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [W-1:0]      time_now,
  input  logic              tick,
  input  logic              end_valid,
  input  logic              end_abort,
  input  logic              end_collision,
  input  logic [STAT_W-1:0] end_status,
  output logic              tx_en,
  output logic              post_valid,
  output logic [1:0]        post_code,
  output logic [STAT_W-1:0] post_status
);
  import txb_pkg::*;

  localparam logic [W-1:0]      MIN_GAP_W = W'(MIN_GAP);
  localparam logic [STAT_W-1:0] MASK_W    = STAT_W'(STAT_MASK);

  sched_state_e state;
  logic [W-1:0] rng_q, rng_next, load_old, last_end;
  logic [W-1:0] rand_wait, elapsed, shortfall, gap_wait, wait_val;
  logic [RND_BITS-1:0] rnd_hi;
  logic gap_ok, overflow, need_wait, ctr_load, ctr_expire;
  logic [W-1:0] ctr_cnt;

  txb_lcg #(.W(W), .SH_A(11), .SH_B(2), .INC(LCG_INC)) u_lcg (
    .clk(clk), .rst(rst), .step(state == ST_ATTEMPT),
    .value(rng_q), .next_value(rng_next)
  );

  txb_load #(.W(W)) u_load (
    .clk(clk), .rst(rst),
    .clear(state == ST_IDLE && cmd_start),
    .step(state == ST_ATTEMPT),
    .load_q(load_old)
  );

  always_comb begin
    rnd_hi    = rng_next[W-1 -: RND_BITS];
    rand_wait = (load_old & W'(rnd_hi)) << 1;
    elapsed   = time_now - last_end;
    gap_ok    = elapsed >= MIN_GAP_W;
    shortfall = MIN_GAP_W - elapsed;
    gap_wait  = (shortfall >> GAP_SHIFT) + W'(1);
    overflow  = load_old[W-1];
    need_wait = (rand_wait != '0) || !gap_ok;
    wait_val  = (rand_wait != '0) ? rand_wait : gap_wait;
    ctr_load  = (state == ST_ATTEMPT) && !overflow && need_wait;
  end

  txb_wait_ctr #(.CW(W)) u_wait (
    .clk(clk), .rst(rst), .load_en(ctr_load), .load_val(wait_val),
    .tick(tick), .cnt(ctr_cnt), .expire(ctr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tx_en       <= 1'b0;
      post_valid  <= 1'b0;
      post_code   <= 2'd0;
      post_status <= '0;
      last_end    <= '0;
    end else begin
      tx_en      <= 1'b0;
      post_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            if (cmd_count == '0) begin
              post_valid  <= 1'b1;
              post_code   <= POST_CNT_ZERO;
              post_status <= '0;
            end else begin
              state <= ST_ATTEMPT;
            end
          end
        end
        ST_ATTEMPT: begin
          if (overflow) begin
            post_valid  <= 1'b1;
            post_code   <= POST_LOAD_OVF;
            post_status <= '0;
            state       <= ST_IDLE;
          end else if (need_wait) begin
            state <= ST_WAIT;
          end else begin
            tx_en <= 1'b1;
            state <= ST_BUSY;
          end
        end
        ST_WAIT: begin
          if (ctr_expire) begin
            tx_en <= 1'b1;
            state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (end_valid) begin
            if (end_abort && end_collision) begin
              state <= ST_ATTEMPT;
            end else begin
              post_valid  <= 1'b1;
              post_code   <= end_abort ? POST_ABORT : POST_DONE;
              post_status <= end_status & MASK_W;
              if (!end_abort) last_end <= time_now;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> !tx_en);
  // R12
  post_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    post_valid |=> !post_valid);
  // R12
  tx_post_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_en && post_valid));
  // R7
  ovf_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (post_valid && post_code == POST_LOAD_OVF) |-> (post_status == '0));
  // R13
  busy_ignore_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !ctr_expire) |=> (state == ST_WAIT) && !post_valid);
endmodule

// File: tb/tx_backoff_sched_bench.sv
`timescale 1ns/1ps
module tx_backoff_sched_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0;
  logic [15:0] cmd_count = '0;
  logic [15:0] time_now = '0;
  logic tick = 1'b0;
  logic end_valid = 1'b0, end_abort = 1'b0, end_collision = 1'b0;
  logic [7:0] end_status = '0;
  logic tx_en, post_valid;
  logic [1:0] post_code;
  logic [7:0] post_status;

  int total = 0, bad = 0;
  int tx_cnt = 0, post_cnt = 0;
  logic [1:0] last_code;
  logic [7:0] last_stat;
  logic [15:0] m_rng = '0, m_load = '0, m_last_end = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tx_backoff_sched u_tx_backoff_sched (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_count(cmd_count),
    .time_now(time_now), .tick(tick), .end_valid(end_valid),
    .end_abort(end_abort), .end_collision(end_collision),
    .end_status(end_status), .tx_en(tx_en), .post_valid(post_valid),
    .post_code(post_code), .post_status(post_status)
  );

  always @(posedge clk) begin
    if (tx_en) tx_cnt <= tx_cnt + 1;
    if (post_valid) begin
      post_cnt  <= post_cnt + 1;
      last_code <= post_code;
      last_stat <= post_status;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
  endtask

  task automatic issue_cmd(input logic [15:0] cnt);
    cmd_count = cnt; cmd_start = 1'b1; cyc(1); cmd_start = 1'b0;
  endtask

  task automatic report_end(input bit ab, input bit col, input logic [7:0] st);
    end_valid = 1'b1; end_abort = ab; end_collision = col; end_status = st;
    cyc(1);
    end_valid = 1'b0; end_abort = 1'b0; end_collision = 1'b0;
  endtask

  // model of one attempt, from R2, R3, R4, R6, R7
  task automatic model_attempt(output int w, output bit ovf);
    logic [15:0] old, el;
    old    = m_load;
    m_load = 16'(32'(old) * 2 + 1);
    m_rng  = 16'(32'(m_rng) * 2053 + 13849);
    ovf    = old[15];
    w      = int'(old & (m_rng >> 8)) * 2;
    if (!ovf && w == 0) begin
      el = time_now - m_last_end;
      if (int'(el) < 840) w = ((840 - int'(el)) >> 5) + 1;
    end
  endtask

  // waits for tx_en after w ticks (w=0: immediate start)
  task automatic await_tx(input int w, input string tag);
    int t0, p0;
    t0 = tx_cnt; p0 = post_cnt;
    cyc(4);
    if (w == 0) begin
      chk(tx_cnt == t0 + 1, tag, tx_cnt - t0, 1);
    end else begin
      chk(tx_cnt == t0, tag, tx_cnt - t0, 0);
      repeat (w - 1) pulse_tick();
      chk(tx_cnt == t0, tag, tx_cnt - t0, 0);
      pulse_tick();
      cyc(2);
      chk(tx_cnt == t0 + 1, tag, tx_cnt - t0, 1);
    end
    chk(post_cnt == p0, {tag, " no post"}, post_cnt - p0, 0);
  endtask

  task automatic expect_post(input int p0, input int code, input int stat, input string tag);
    cyc(3);
    chk(post_cnt == p0 + 1, {tag, " post count"}, post_cnt - p0, 1);
    chk(int'(last_code) == code, {tag, " code"}, last_code, code);
    chk(int'(last_stat) == stat, {tag, " status"}, last_stat, stat);
  endtask

  task automatic start_attempt_from_cmd(input string tag);
    int w; bit ovf;
    issue_cmd(16'd10);
    m_load = '0;
    model_attempt(w, ovf);
    await_tx(w, tag);
  endtask

  task automatic test_reset();
    cyc(1);
    chk(tx_en == 1'b0, "R1 tx_en after reset", tx_en, 0);
    chk(post_valid == 1'b0, "R1 post_valid after reset", post_valid, 0);
  endtask

  task automatic test_first_and_success();
    int p0;
    time_now = 16'd5000;
    start_attempt_from_cmd("R1 R5 first attempt immediate");
    p0 = post_cnt;
    report_end(1'b0, 1'b0, 8'hFF);
    m_last_end = time_now;
    expect_post(p0, 0, 'hFF & 'h3C, "R11 success");
  endtask

  task automatic test_short_gap_and_ignore();
    int w; bit ovf; int t0, p0;
    time_now = 16'd5100;
    issue_cmd(16'd4);
    m_load = '0;
    model_attempt(w, ovf);
    chk(w == 24, "R6 model gap wait", w, 24);
    t0 = tx_cnt; p0 = post_cnt;
    cyc(3);
    repeat (10) pulse_tick();
    issue_cmd(16'd0);
    cyc(3);
    chk(post_cnt == p0, "R13 cmd ignored while waiting", post_cnt - p0, 0);
    repeat (13) pulse_tick();
    chk(tx_cnt == t0, "R6 no start before shortfall ticks", tx_cnt - t0, 0);
    pulse_tick();
    cyc(2);
    chk(tx_cnt == t0 + 1, "R6 start after shortfall ticks", tx_cnt - t0, 1);
    p0 = post_cnt;
    report_end(1'b1, 1'b0, 8'hA5);
    expect_post(p0, 1, 'hA5 & 'h3C, "R10 abort");
  endtask

  task automatic test_gap_edges();
    int p0;
    time_now = m_last_end + 16'd840;
    start_attempt_from_cmd("R5 gap exactly minimum");
    p0 = post_cnt;
    report_end(1'b0, 1'b0, 8'h0F);
    m_last_end = time_now;
    expect_post(p0, 0, 'h0F & 'h3C, "R11 success stamp");
    time_now = m_last_end + 16'd839;
    start_attempt_from_cmd("R6 gap one below minimum");
    p0 = post_cnt;
    report_end(1'b0, 1'b0, 8'h30);
    m_last_end = time_now;
    expect_post(p0, 0, 'h30, "R11 success second");
  endtask

  task automatic test_count_zero();
    int p0, t0;
    p0 = post_cnt; t0 = tx_cnt;
    issue_cmd(16'd0);
    expect_post(p0, 2, 0, "R8 count zero");
    chk(tx_cnt == t0, "R8 no tx on count zero", tx_cnt - t0, 0);
  endtask

  task automatic test_collisions();
    int w, p0; bit ovf;
    time_now = 16'd20000;
    start_attempt_from_cmd("R2 R3 fresh attempt");
    for (int i = 1; i <= 16; i++) begin
      p0 = post_cnt;
      report_end(1'b1, 1'b1, 8'hFF);
      model_attempt(w, ovf);
      if (ovf) begin
        chk(i == 16, "R7 overflow at expected retry", i, 16);
        expect_post(p0, 3, 0, "R7 load overflow");
      end else begin
        await_tx(w, $sformatf("R4 R9 retry %0d", i));
      end
    end
  endtask

  task automatic test_clear_after_overflow();
    int p0;
    time_now = 16'd30000;
    start_attempt_from_cmd("R3 fresh command clears load");
    p0 = post_cnt;
    report_end(1'b0, 1'b0, 8'h04);
    m_last_end = time_now;
    expect_post(p0, 0, 'h04, "R11 final success");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    test_reset();
    test_first_and_success();
    test_short_gap_and_ignore();
    test_gap_edges();
    test_count_zero();
    test_collisions();
    test_clear_after_overflow();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule